// File: doc/BRIEF.md
# Serial-Clocked Successive-Approximation Sequencer

This block is the digital half of a 16-bit successive-approximation converter whose only timing source is the host's serial clock. An active-low chip select powers the block up and starts a sample. The block then counts falling serial-clock edges to end acquisition, steps a trial code through a binary search driven by an external comparator decision, and shifts the result out MSB first. The output frame has eight zero bits, then the 16 result bits, then zeros for as long as the host keeps clocking.

The host drives chip select and the serial clock and samples the data output on rising edges. The DAC code output feeds the capacitive array, and the hold output opens the sampling switch. The analog comparator answers whether the held input is at or above the current trial code. Raising chip select at any moment, mid-conversion included, aborts the sample, clears every register and returns the block to shutdown.

Top module: `sar_serial_seq`

## Requirements
- R1: While chip select is high the block is in shutdown: `sdo_en` is 0 and `sdo` is high impedance, `pwr_up` is 0, `hold` is 0, `dac_code` is 0 and `seq_err` is 0.
- R2: After chip select falls and before the first falling serial-clock edge, `sdo_en` is 1 and `sdo` is driven to logic 0.
- R3: `hold` is 0 until the 6th falling serial-clock edge after chip select falls. It is 1 from that edge until chip select rises.
- R4: On the 6th falling edge `dac_code` becomes 16'h8000. On each of the next 16 falling edges one bit is decided, working from the MSB down: the current trial bit is kept if `comp_hi` is 1 and cleared if it is 0, and the next lower bit is set as the new trial. After the 22nd edge `dac_code` holds the final result.
- R5: `sdo` changes only on falling edges. It is 0 after falling edges 0 to 7. After falling edge 8+i it carries result bit 15-i, for i from 0 to 15.
- R6: After falling edge 24 and every later edge while chip select stays low, `sdo` is 0, `hold` stays 1 and `dac_code` does not change.
- R7: A chip-select rise at any edge count, including mid-conversion, returns the block to the R1 state at once, without a clock edge. The next chip-select fall starts a normal conversion.
- R8: The 16 bits shifted out form straight unipolar binary: with an ideal comparator (`comp_hi` = input code >= `dac_code`) they equal the input code, from 16'h0000 up to 16'hFFFF.
- R9: Every result bit is decided on an earlier edge than the one that shifts it out. With the default parameters, `seq_err` stays 0 for the whole frame.
- R10: `pwr_up` is 1 exactly while chip select is low and `rst_n` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| cs_n | input | 1 | Active-low chip select; high aborts and shuts down |
| sclk | input | 1 | Serial clock; all state advances on its falling edge |
| comp_hi | input | 1 | Comparator decision: held input is at or above `dac_code` |
| dac_code | output | 16 | Trial code for the capacitive DAC |
| hold | output | 1 | Track/hold control, 1 = hold |
| sdo | output | 1 | Serial data output, high impedance in shutdown |
| sdo_en | output | 1 | Output-drive enable for `sdo` |
| pwr_up | output | 1 | Power-state indication, 1 = powered |
| seq_err | output | 1 | A bit was shifted out before it was decided |

## Verification
All results are tied to the count of falling edges since chip select fell. `hold` and the first trial code are due right after edge 6. The trial code for each later bit is due one edge after that bit's trial began. `sdo` carries bit 15-i right after edge 8+i. So the bench counts falling edges itself and compares every output at the rising edge that follows, half a period from any change. The comparator model is also updated on the rising edge, so the design samples a settled decision. Abort and wake-up are asynchronous, so they are checked a fraction of a nanosecond after chip select moves rather than at a clock edge.

// File: rtl/sar_seq_pkg.sv
`timescale 1ns/1ps
package sar_seq_pkg;
  // Default geometry of the conversion frame
  localparam int unsigned DEF_RES_BITS   = 16; // result width
  localparam int unsigned DEF_LEAD_ZEROS = 8;  // zero bits ahead of the MSB
  localparam int unsigned DEF_ACQ_EDGES  = 6;  // falling edge that ends tracking

  // Coarse phase of a frame, decoded from the edge count
  typedef enum logic [1:0] {
    PH_TRACK   = 2'd0,
    PH_RESOLVE = 2'd1,
    PH_DRAIN   = 2'd2
  } sar_phase_e;
endpackage

// File: rtl/sar_edge_counter.sv
`timescale 1ns/1ps
module sar_edge_counter #(
  parameter int unsigned FRAME_LEN = 24,
  parameter int unsigned ACQ_EDGES = 6,
  parameter int unsigned RES_BITS  = 16,
  localparam int unsigned CNT_W    = $clog2(FRAME_LEN + 1)
) (
  input  logic                    clk_n,
  input  logic                    arst_n,
  output logic [CNT_W-1:0]        cnt,
  output sar_seq_pkg::sar_phase_e phase
);
  import sar_seq_pkg::*;

  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_LEN);
  localparam logic [CNT_W-1:0] CNT_ACQ  = CNT_W'(ACQ_EDGES);
  localparam logic [CNT_W-1:0] CNT_DONE = CNT_W'(ACQ_EDGES + RES_BITS);

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             cnt_en;

  // Saturate at the frame length: trailing clocks leave the count parked
  always_comb begin
    cnt_en = (cnt_q != CNT_LAST);
    cnt_n  = cnt_q + 1'b1;
  end

  always_ff @(negedge clk_n or negedge arst_n) begin
    if (!arst_n)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_n;
  end

  always_comb begin
    if (cnt_q < CNT_ACQ)       phase = PH_TRACK;
    else if (cnt_q < CNT_DONE) phase = PH_RESOLVE;
    else                       phase = PH_DRAIN;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/sar_trial_reg.sv
`timescale 1ns/1ps
module sar_trial_reg #(
  parameter int unsigned RES_BITS = 16
) (
  input  logic                clk_n,
  input  logic                arst_n,
  input  logic                load,
  input  logic                comp_hi,
  output logic [RES_BITS-1:0] code,
  output logic [RES_BITS-1:0] resolved,
  output logic [RES_BITS-1:0] probe,
  output logic                last_bit
);
  localparam logic [RES_BITS-1:0] MSB_ONE = {1'b1, {(RES_BITS-1){1'b0}}};

  logic [RES_BITS-1:0] code_q, code_n;
  logic [RES_BITS-1:0] res_q, res_n;
  logic [RES_BITS-1:0] probe_q, probe_n;
  logic                last_q, last_n;
  logic                busy, upd_en;

  assign busy   = |probe_q;
  assign upd_en = load | busy;

  // Binary search: decide the bit under trial, then move the trial one place down
  always_comb begin
    code_n  = code_q;
    res_n   = res_q;
    probe_n = probe_q;
    last_n  = last_q;
    if (load) begin
      code_n  = MSB_ONE;
      probe_n = MSB_ONE;
    end else if (busy) begin
      code_n  = comp_hi ? code_q : (code_q & ~probe_q);
      probe_n = probe_q >> 1;
      code_n  = code_n | probe_n;
      res_n   = res_q | probe_q;
      last_n  = comp_hi;
    end
  end

  always_ff @(negedge clk_n or negedge arst_n) begin
    if (!arst_n) begin
      code_q  <= '0;
      res_q   <= '0;
      probe_q <= '0;
      last_q  <= 1'b0;
    end else if (upd_en) begin
      code_q  <= code_n;
      res_q   <= res_n;
      probe_q <= probe_n;
      last_q  <= last_n;
    end
  end

  assign code     = code_q;
  assign resolved = res_q;
  assign probe    = probe_q;
  assign last_bit = last_q;
endmodule

// File: rtl/sar_shift_out.sv
`timescale 1ns/1ps
module sar_shift_out #(
  parameter int unsigned RES_BITS   = 16,
  parameter int unsigned LEAD_ZEROS = 8,
  parameter int unsigned CNT_W      = 5
) (
  input  logic                clk_n,
  input  logic                arst_n,
  input  logic [CNT_W-1:0]    cnt,
  input  logic [RES_BITS-1:0] code,
  input  logic [RES_BITS-1:0] resolved,
  input  logic                last_bit,
  output logic                out_bit,
  output logic                err
);
  localparam logic [RES_BITS-1:0] MSB_ONE = {1'b1, {(RES_BITS-1){1'b0}}};
  // The pointer is armed one edge ahead of the MSB slot; LEAD_ZEROS must be 2 or more
  localparam logic [CNT_W-1:0]    CNT_ARM = CNT_W'(LEAD_ZEROS - 2);

  logic [RES_BITS-1:0] tap_q, tap_n;
  logic                bit_q, bit_n;
  logic                err_q, err_n;

  always_comb begin
    tap_n = (cnt == CNT_ARM) ? MSB_ONE : (tap_q >> 1);
    bit_n = 1'b0;
    err_n = err_q;
    if (|tap_q) begin
      if (|(resolved & tap_q)) begin
        bit_n = |(code & tap_q);
      end else begin
        bit_n = last_bit;   // fall back to the newest decided bit
        err_n = 1'b1;
      end
    end
  end

  always_ff @(negedge clk_n or negedge arst_n) begin
    if (!arst_n) begin
      tap_q <= '0;
      bit_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      tap_q <= tap_n;
      bit_q <= bit_n;
      err_q <= err_n;
    end
  end

  assign out_bit = bit_q;
  assign err     = err_q;
endmodule

// File: rtl/sar_serial_seq.sv
`timescale 1ns/1ps
module sar_serial_seq #(
  parameter int unsigned RES_BITS   = sar_seq_pkg::DEF_RES_BITS,
  parameter int unsigned LEAD_ZEROS = sar_seq_pkg::DEF_LEAD_ZEROS,
  parameter int unsigned ACQ_EDGES  = sar_seq_pkg::DEF_ACQ_EDGES
) (
  input  logic                rst_n,
  input  logic                cs_n,
  input  logic                sclk,
  input  logic                comp_hi,
  output logic [RES_BITS-1:0] dac_code,
  output logic                hold,
  output logic                sdo,
  output logic                sdo_en,
  output logic                pwr_up,
  output logic                seq_err
);
  import sar_seq_pkg::*;

  localparam int unsigned FRAME_LEN = LEAD_ZEROS + RES_BITS;
  localparam int unsigned CNT_W     = $clog2(FRAME_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_ACQ_EDGE = CNT_W'(ACQ_EDGES - 1);

  logic                arst_n;
  logic [CNT_W-1:0]    edge_cnt;
  sar_phase_e          phase;
  logic                acq_edge;
  logic                hold_q, hold_n;
  logic [RES_BITS-1:0] sar_code, sar_resolved, sar_probe;
  logic                sar_last;
  logic                out_bit, out_err;

  // Chip select high acts as an asynchronous clear of the whole block
  assign arst_n = rst_n & ~cs_n;

  sar_edge_counter #(
    .FRAME_LEN(FRAME_LEN), .ACQ_EDGES(ACQ_EDGES), .RES_BITS(RES_BITS)
  ) u_cnt (
    .clk_n(sclk), .arst_n(arst_n), .cnt(edge_cnt), .phase(phase)
  );

  // Edge that closes acquisition
  assign acq_edge = (edge_cnt == CNT_ACQ_EDGE) && (phase == PH_TRACK);

  always_comb hold_n = hold_q | acq_edge;

  always_ff @(negedge sclk or negedge arst_n) begin
    if (!arst_n) hold_q <= 1'b0;
    else         hold_q <= hold_n;
  end

  sar_trial_reg #(.RES_BITS(RES_BITS)) u_sar (
    .clk_n(sclk), .arst_n(arst_n), .load(acq_edge), .comp_hi(comp_hi),
    .code(sar_code), .resolved(sar_resolved), .probe(sar_probe),
    .last_bit(sar_last)
  );

  sar_shift_out #(
    .RES_BITS(RES_BITS), .LEAD_ZEROS(LEAD_ZEROS), .CNT_W(CNT_W)
  ) u_out (
    .clk_n(sclk), .arst_n(arst_n), .cnt(edge_cnt), .code(sar_code),
    .resolved(sar_resolved), .last_bit(sar_last),
    .out_bit(out_bit), .err(out_err)
  );

  assign dac_code = sar_code;
  assign hold     = hold_q;
  assign sdo_en   = rst_n & ~cs_n;
  assign pwr_up   = rst_n & ~cs_n;
  assign sdo      = sdo_en ? out_bit : 1'bz;
  assign seq_err  = out_err;
endmodule

// File: rtl/sar_serial_seq_chk.sv
`timescale 1ns/1ps
module sar_serial_seq_chk #(
  parameter int unsigned RES_BITS   = 16,
  parameter int unsigned LEAD_ZEROS = 8,
  parameter int unsigned ACQ_EDGES  = 6,
  parameter int unsigned CNT_W      = 5
) (
  input logic                sclk,
  input logic                rst_n,
  input logic                cs_n,
  input logic [CNT_W-1:0]    cnt,
  input logic                hold,
  input logic [RES_BITS-1:0] dac_code,
  input logic                sdo_en,
  input logic                pwr_up,
  input logic                seq_err,
  input logic [RES_BITS-1:0] probe,
  input logic                out_bit
);
  localparam logic [CNT_W-1:0] C_ACQ   = CNT_W'(ACQ_EDGES);
  localparam logic [CNT_W-1:0] C_LEAD  = CNT_W'(LEAD_ZEROS);
  localparam logic [CNT_W-1:0] C_FRAME = CNT_W'(LEAD_ZEROS + RES_BITS);

  // Sampled on the rising edge, half a period away from every state change
  assert_shutdown_R1: assert property (@(posedge sclk) disable iff (!rst_n)
    cs_n |-> (!sdo_en && !pwr_up && !hold && dac_code == '0 && !seq_err));

  assert_track_R3: assert property (@(posedge sclk) disable iff (!rst_n)
    (!cs_n && cnt < C_ACQ) |-> !hold);

  assert_hold_R3: assert property (@(posedge sclk) disable iff (!rst_n)
    (!cs_n && cnt >= C_ACQ) |-> hold);

  assert_first_trial_R4: assert property (@(posedge sclk) disable iff (!rst_n)
    (!cs_n && cnt == C_ACQ) |-> dac_code == {1'b1, {(RES_BITS-1){1'b0}}});

  assert_one_trial_R4: assert property (@(posedge sclk) disable iff (!rst_n)
    $onehot0(probe));

  assert_lead_zero_R5: assert property (@(posedge sclk) disable iff (!rst_n)
    (!cs_n && cnt < C_LEAD) |-> !out_bit);

  assert_drain_R6: assert property (@(posedge sclk) disable iff (!rst_n || cs_n)
    (cnt == C_FRAME && $past(cnt) == C_FRAME && !$past(cs_n))
      |-> ($stable(dac_code) && !out_bit));

  assert_no_err_R9: assert property (@(posedge sclk) disable iff (!rst_n)
    !seq_err);

  assert_power_R10: assert property (@(posedge sclk) disable iff (!rst_n)
    pwr_up == !cs_n);
endmodule

bind sar_serial_seq sar_serial_seq_chk #(
  .RES_BITS(RES_BITS), .LEAD_ZEROS(LEAD_ZEROS), .ACQ_EDGES(ACQ_EDGES),
  .CNT_W(CNT_W)
) u_chk (
  .sclk(sclk), .rst_n(rst_n), .cs_n(cs_n), .cnt(edge_cnt), .hold(hold),
  .dac_code(dac_code), .sdo_en(sdo_en), .pwr_up(pwr_up), .seq_err(seq_err),
  .probe(sar_probe), .out_bit(out_bit)
);

// File: tb/tb_sar_serial_seq.sv
`timescale 1ns/1ps
module tb_sar_serial_seq;
  localparam int RES  = 16;
  localparam int LEAD = 8;
  localparam int ACQ  = 6;

  logic            rst_n, cs_n, sclk, comp_hi;
  logic [RES-1:0]  dac_code;
  logic            hold, sdo, sdo_en, pwr_up, seq_err;

  int              checks = 0;
  int              errors = 0;
  int              n = 0;           // falling edges seen since chip select fell
  logic [RES-1:0]  vin = '0;        // ideal input code
  logic [RES-1:0]  word = '0;       // bits captured from sdo
  bit              done = 0;

  sar_serial_seq dut (
    .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .comp_hi(comp_hi),
    .dac_code(dac_code), .hold(hold), .sdo(sdo), .sdo_en(sdo_en),
    .pwr_up(pwr_up), .seq_err(seq_err)
  );

  initial sclk = 1'b1;
  always #2 sclk = ~sclk;   // 250 MHz

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at n=%0d: actual %h expected %h", req, n, act, exp);
    end
  endtask

  function automatic logic [RES-1:0] exp_dac(int e, logic [RES-1:0] v);
    int k;
    logic [31:0] mask;
    if (e < ACQ) return '0;
    k = e - ACQ;
    if (k >= RES) return v;
    mask = (32'hFFFF << (RES - k)) & 32'hFFFF;
    return RES'((32'(v) & mask) | (32'h1 << (RES - 1 - k)));
  endfunction

  function automatic logic exp_sdo(int e, logic [RES-1:0] v);
    if (e < LEAD || e >= LEAD + RES) return 1'b0;
    return v[RES - 1 - (e - LEAD)];
  endfunction

  // Edge count model
  always @(negedge sclk) begin
    if (cs_n) n <= 0;
    else      n <= n + 1;
  end

  // Ideal comparator, settled half a period before the deciding edge
  always @(posedge sclk) comp_hi <= (vin >= dac_code);

  // Per-clock comparison against the reference model
  always @(posedge sclk) begin
    if (rst_n) begin
      if (cs_n) begin
        chk("R1 sdo_en", 32'(sdo_en), 0);
        chk("R1 pwr_up", 32'(pwr_up), 0);
        chk("R1 hold", 32'(hold), 0);
        chk("R1 dac_code", 32'(dac_code), 0);
        chk("R1 seq_err", 32'(seq_err), 0);
      end else begin
        chk("R2 sdo_en", 32'(sdo_en), 1);
        chk("R10 pwr_up", 32'(pwr_up), 1);
        chk("R3 hold", 32'(hold), (n >= ACQ) ? 1 : 0);
        chk((n >= LEAD + RES) ? "R6 dac_code" : "R4 dac_code",
            32'(dac_code), 32'(exp_dac(n, vin)));
        chk((n >= LEAD + RES) ? "R6 sdo" : "R5 sdo",
            32'(sdo), 32'(exp_sdo(n, vin)));
        chk("R9 seq_err", 32'(seq_err), 0);
        if (n >= LEAD && n < LEAD + RES) word = {word[RES-2:0], sdo};
        if (n == LEAD + RES) chk("R8 result word", 32'(word), 32'(vin));
      end
    end
  end

  // One frame: wake, clock `edges` falling edges, then raise chip select
  task automatic frame(logic [RES-1:0] v, int edges);
    @(posedge sclk); #1;
    vin  = v;
    word = '0;
    cs_n = 1'b0;
    #0.5;
    chk("R2 wake drive", 32'(sdo_en), 1);
    chk("R2 wake low", 32'(sdo), 0);
    chk("R10 wake power", 32'(pwr_up), 1);
    repeat (edges) @(negedge sclk);
    @(posedge sclk); #1;
    cs_n = 1'b1;
    #0.5;
    chk("R7 abort drive", 32'(sdo_en), 0);
    chk("R7 abort hold", 32'(hold), 0);
    chk("R7 abort dac", 32'(dac_code), 0);
    chk("R7 abort power", 32'(pwr_up), 0);
    repeat (2) @(posedge sclk);
  endtask

  initial begin
    logic [RES-1:0] lf;
    rst_n = 1'b0;
    cs_n  = 1'b1;
    comp_hi = 1'b0;
    repeat (3) @(posedge sclk);
    #1 rst_n = 1'b1;
    repeat (2) @(posedge sclk);
    // reset / shutdown state
    chk("R1 reset sdo_en", 32'(sdo_en), 0);
    chk("R1 reset dac", 32'(dac_code), 0);

    frame(16'hA5C3, 24);
    frame(16'h0000, 24);          // R8 zero scale
    frame(16'hFFFF, 24);          // R8 full scale
    frame(16'h8000, 30);          // R6 trailing zeros
    frame(16'h7FFF, 24);
    frame(16'h0001, 40);          // R6 long drain
    frame(16'h1234, 12);          // R7 abort mid-conversion
    frame(16'h4321, 24);          // R7 normal after abort
    frame(16'hBEEF, 3);           // R7 abort during tracking
    frame(16'hC0DE, 7);           // R7 abort just after first decision
    frame(16'h5A5A, 24);
    lf = 16'hACE1;
    for (int i = 0; i < 12; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      frame(lf, 24 + (i % 3));
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge sclk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule